// File: doc/BRIEF.md
# Separable Row-Column Gaussian Blur

This block applies a 5x5 Gaussian smoothing kernel to a raster-ordered stream of 8-bit pixels. It does this in two one-dimensional passes. A horizontal stage weights five consecutive pixels of the same row. A vertical stage then weights five horizontal results that share a column, taken from five consecutive rows. The five tap weights are unsigned fixed-point values with 15 fractional bits. Both passes use the same weights: 1963, 7238, 11957, 7238, 1963 (about 0.0599, 0.2209, 0.3649, 0.2209, 0.0599).

Horizontal results are written at full precision into five row banks. A modulo-5 bank selector moves to the next bank at the end of every image row. When a new horizontal result arrives, the other four banks are read at the same column address in the same cycle. Those four values and the new result go to the vertical stage together, so the vertical pass adds no serial steps. The block produces a result only for interior window positions; it does no border replication. Reset marks the start of a frame, and the image width is a parameter.

Top module: `gsb_sep_blur`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` stays low until a complete 5x5 window has been received. Pixels streamed before a reset have no effect on any output after that reset.
- R2: The horizontal pass forms C0*p[c-4] + C1*p[c-3] + C2*p[c-2] + C1*p[c-1] + C0*p[c] over the pixels of one row. The weights are C0=1963, C1=7238 and C2=11957, each a 16-bit unsigned value with 15 fractional bits. The vertical pass applies the same weights to horizontal results from rows r-4 to r.
- R3: The row-bank selector counts modulo 5. It advances only on the last pixel of a row. A sixth row therefore overwrites the oldest stored row, and results stay correct on every later row.
- R4: Counting rows and columns from 0 after reset, an output is produced only for input pixels at row >= 4 and column >= 4. Each such row gives exactly IMG_W-4 outputs.
- R5: The full 30-fractional-bit vertical sum is rounded once: 2^29 is added, the sum is shifted right by 30, and the result is saturated at 255. Horizontal results keep every fractional bit.
- R6: `out_valid` rises exactly two clock cycles after the `in_valid` cycle of the pixel at (r, c). The output value belongs to the window centred on (r-2, c-2).
- R7: Cycles with `in_valid` low change no state. Arbitrary idle gaps inside the stream leave every output value unchanged.
- R8: A frame in which every pixel is 255 gives 219 at every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also marks frame start |
| in_valid | input | 1 | Pixel strobe |
| in_pix | input | PIX_W | Input pixel, raster order |
| out_valid | output | 1 | Filtered pixel strobe |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
A wrong bank selector or a wrong read order feeds mismatched rows into the vertical stage. This shows up as wrong values from the sixth row onward, within IMG_W input pixels. A row or column counter that is off by one shifts `out_valid` to the wrong positions or changes the number of outputs per row. This is visible at the first interior pixel, two cycles after its input. A wrong weight or a wrong rounding step changes individual output values right away. The impulse and uniform frames make such errors easy to tell apart from each other.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
   localparam int TAPS   = 5;
   localparam int BANK_W = $clog2(TAPS);

   typedef logic [BANK_W-1:0] bank_t;

   // bank holding the row that lies `back` rows before bank `b`
   function automatic int bank_back(input bank_t b, input int back);
      int idx;
      idx = int'(b) - back;
      if (idx < 0) idx = idx + TAPS;
      return idx;
   endfunction
endpackage

// File: rtl/gsb_raster.sv
module gsb_raster
   import gsb_pkg::*;
#(
   parameter int IMG_W = 32,
   localparam int CW   = $clog2(IMG_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   output logic [CW-1:0] col,
   output bank_t         bank,
   output logic          h_ready,
   output logic          rows_full
);
   localparam int ROWS_W = $clog2(TAPS);

   logic [ROWS_W-1:0] rows_done;
   logic              row_end;

   assign row_end   = pix_valid && (col == CW'(IMG_W - 1));
   assign h_ready   = (col >= CW'(TAPS - 1));
   assign rows_full = (rows_done == ROWS_W'(TAPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col       <= '0;
         bank      <= '0;
         rows_done <= '0;
      end else if (pix_valid) begin
         if (row_end) begin
            col  <= '0;
            bank <= (bank == bank_t'(TAPS - 1)) ? '0 : bank + 1'b1;
            if (!rows_full) rows_done <= rows_done + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   // R3: the bank selector only moves on a row's last pixel
   assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !row_end |=> $stable(bank));
endmodule

// File: rtl/gsb_row_pe.sv
module gsb_row_pe
   import gsb_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   parameter int K_EDGE = 1963,
   parameter int K_NEAR = 7238,
   parameter int K_MID  = 11957,
   parameter int SUM_W  = PIX_W + COEF_W + $clog2(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix,
   input  logic             emit,
   output logic             res_valid,
   output logic [SUM_W-1:0] res
);
   localparam logic [COEF_W-1:0] COEF [TAPS] =
      '{COEF_W'(K_EDGE), COEF_W'(K_NEAR), COEF_W'(K_MID),
        COEF_W'(K_NEAR), COEF_W'(K_EDGE)};

   logic [PIX_W-1:0] hist [TAPS-1];
   logic [PIX_W-1:0] win  [TAPS];
   logic [SUM_W-1:0] sum;

   always_comb begin
      win[0] = pix;
      for (int k = 1; k < TAPS; k++) win[k] = hist[k-1];
   end

   always_comb begin
      sum = '0;
      for (int k = 0; k < TAPS; k++)
         sum = sum + SUM_W'(COEF[k]) * SUM_W'(win[k]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
         res_valid <= 1'b0;
         res       <= '0;
      end else begin
         res_valid <= pix_valid && emit;
         if (pix_valid) begin
            hist[0] <= pix;
            for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
            if (emit) res <= sum;
         end
      end
   end

   // R7: an idle input cycle never yields a horizontal result
   assert_no_result_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !res_valid);
endmodule

// File: rtl/gsb_row_banks.sv
module gsb_row_banks
   import gsb_pkg::*;
#(
   parameter int SUM_W = 27,
   parameter int DEPTH = 28,
   localparam int AW   = $clog2(DEPTH),
   localparam int SLOTS = 1 << AW
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_valid,
   input  bank_t                       wr_bank,
   input  logic [AW-1:0]               wr_addr,
   input  logic [SUM_W-1:0]            wr_data,
   output logic [TAPS-1:0][SUM_W-1:0]  taps
);
   logic [SUM_W-1:0] rd [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_bank
      logic [SUM_W-1:0] mem [SLOTS];
      always_ff @(posedge clk) begin
         if (wr_valid && (wr_bank == bank_t'(g))) mem[wr_addr] <= wr_data;
      end
      assign rd[g] = mem[wr_addr];
   end

   // merge: oldest row in taps[0], the arriving result in taps[TAPS-1]
   always_comb begin
      taps[TAPS-1] = wr_data;
      for (int j = 0; j < TAPS - 1; j++)
         taps[j] = rd[bank_back(wr_bank, TAPS - 1 - j)];
   end

   // R4: only interior columns are ever written
   assert_addr_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/gsb_col_pe.sv
module gsb_col_pe
   import gsb_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 15,
   parameter int K_EDGE = 1963,
   parameter int K_NEAR = 7238,
   parameter int K_MID  = 11957,
   parameter int SUM_W  = 27
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_full,
   input  logic [TAPS-1:0][SUM_W-1:0] taps,
   output logic                       out_valid,
   output logic [PIX_W-1:0]           out_pix
);
   localparam int ACC_W = SUM_W + COEF_W + $clog2(TAPS);
   localparam int SHIFT = 2 * FRAC_W;
   localparam int RES_W = ACC_W - SHIFT;
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
   localparam logic [COEF_W-1:0] COEF [TAPS] =
      '{COEF_W'(K_EDGE), COEF_W'(K_NEAR), COEF_W'(K_MID),
        COEF_W'(K_NEAR), COEF_W'(K_EDGE)};

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] rounded;
   logic [PIX_W-1:0] clipped;

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++)
         acc = acc + ACC_W'(COEF[k]) * ACC_W'(taps[k]);
      rounded = (acc + HALF) >> SHIFT;
   end

   if (RES_W > PIX_W) begin : g_sat
      localparam logic [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);
      assign clipped = (rounded > PMAX) ? {PIX_W{1'b1}} : rounded[PIX_W-1:0];
   end else begin : g_nosat
      assign clipped = rounded[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid && in_full;
         if (in_valid && in_full) out_pix <= clipped;
      end
   end

   // R4: no output while fewer than five rows are stored
   assert_no_early_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_full |=> !out_valid);
endmodule

// File: rtl/gsb_sep_blur.sv
module gsb_sep_blur
   import gsb_pkg::*;
#(
   parameter int IMG_W  = 32,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 15,
   parameter int K_EDGE = 1963,
   parameter int K_NEAR = 7238,
   parameter int K_MID  = 11957
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] in_pix,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix
);
   localparam int CW    = $clog2(IMG_W);
   localparam int DEPTH = IMG_W - (TAPS - 1);
   localparam int AW    = $clog2(DEPTH);
   localparam int SUM_W = PIX_W + COEF_W + $clog2(TAPS);

   initial begin
      assert (IMG_W >= TAPS + 1) else $fatal(1, "IMG_W too small");
      assert (2 * K_EDGE + 2 * K_NEAR + K_MID <= (1 << FRAC_W))
         else $fatal(1, "weights exceed unity gain");
      assert (COEF_W > FRAC_W) else $fatal(1, "COEF_W must exceed FRAC_W");
   end

   logic [CW-1:0] col;
   bank_t         bank;
   logic          h_ready, rows_full;

   gsb_raster #(.IMG_W(IMG_W)) u_raster (
      .clk(clk), .rst_n(rst_n), .pix_valid(in_valid),
      .col(col), .bank(bank), .h_ready(h_ready), .rows_full(rows_full));

   logic             h_valid;
   logic [SUM_W-1:0] h_res;

   gsb_row_pe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .K_EDGE(K_EDGE),
                .K_NEAR(K_NEAR), .K_MID(K_MID), .SUM_W(SUM_W)) u_row (
      .clk(clk), .rst_n(rst_n), .pix_valid(in_valid), .pix(in_pix),
      .emit(h_ready), .res_valid(h_valid), .res(h_res));

   // position tags travel with the horizontal result
   bank_t         h_bank;
   logic [AW-1:0] h_addr;
   logic          h_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_bank <= '0;
         h_addr <= '0;
         h_full <= 1'b0;
      end else if (in_valid) begin
         h_bank <= bank;
         h_addr <= AW'(col - CW'(TAPS - 1));
         h_full <= rows_full;
      end
   end

   logic [TAPS-1:0][SUM_W-1:0] taps;

   gsb_row_banks #(.SUM_W(SUM_W), .DEPTH(DEPTH)) u_banks (
      .clk(clk), .rst_n(rst_n), .wr_valid(h_valid), .wr_bank(h_bank),
      .wr_addr(h_addr), .wr_data(h_res), .taps(taps));

   gsb_col_pe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
                .K_EDGE(K_EDGE), .K_NEAR(K_NEAR), .K_MID(K_MID),
                .SUM_W(SUM_W)) u_col (
      .clk(clk), .rst_n(rst_n), .in_valid(h_valid), .in_full(h_full),
      .taps(taps), .out_valid(out_valid), .out_pix(out_pix));

   // R6: every output comes two cycles after an accepted pixel
   assert_latency_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/gsb_sep_blur_tb.sv
module gsb_sep_blur_tb;
   localparam int W    = 12;
   localparam int H    = 8;
   localparam int NOUT = (H - 4) * (W - 4);
   localparam int C0 = 1963, C1 = 7238, C2 = 11957;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, in_valid;
   logic [7:0] in_pix;
   logic       out_valid;
   logic [7:0] out_pix;

   gsb_sep_blur #(.IMG_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix));

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0] img [H][W];
   int         in_cyc [H][W];
   int         got_n;
   logic [7:0] got_pix [NOUT];
   int         got_cyc [NOUT];
   logic       collect = 1'b0;
   logic [15:0] lfsr;

   always @(negedge clk) begin
      if (collect && out_valid) begin
         if (got_n < NOUT) begin
            got_pix[got_n] = out_pix;
            got_cyc[got_n] = cyc;
         end
         got_n++;
      end
   end

   // kind[11:8] gap[7] seed[6:0]
   localparam logic [11:0] PLAN [6] = '{
      {4'd0, 1'b0, 7'd0},    // uniform 255
      {4'd1, 1'b0, 7'd0},    // all zero
      {4'd2, 1'b0, 7'd9},    // horizontal ramp
      {4'd3, 1'b0, 7'd0},    // impulse
      {4'd4, 1'b0, 7'd37},   // pseudo-random
      {4'd4, 1'b1, 7'd91}    // pseudo-random with gaps
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint hpass(int r, int c);
      return longint'(C0) * img[r][c-4] + longint'(C1) * img[r][c-3] +
             longint'(C2) * img[r][c-2] + longint'(C1) * img[r][c-1] +
             longint'(C0) * img[r][c];
   endfunction

   function automatic int ref_px(int r, int c);
      longint v;
      v = C0 * hpass(r-4, c) + C1 * hpass(r-3, c) + C2 * hpass(r-2, c) +
          C1 * hpass(r-1, c) + C0 * hpass(r, c);
      v = (v + (longint'(1) << 29)) >>> 30;
      return (v > 255) ? 255 : int'(v);
   endfunction

   function automatic logic [15:0] step(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic fill(input int kind, input int seed);
      lfsr = 16'hACE1 ^ 16'(seed);
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            lfsr = step(lfsr);
            case (kind)
               0: img[r][c] = 8'd255;
               1: img[r][c] = 8'd0;
               2: img[r][c] = 8'(c * 20 + seed);
               3: img[r][c] = (r == 4 && c == 6) ? 8'd255 : 8'd0;
               default: img[r][c] = lfsr[7:0];
            endcase
         end
   endtask

   task automatic push(input logic [7:0] p);
      in_valid = 1'b1; in_pix = p;
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; in_pix = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic run_frame(input logic gaps);
      got_n = 0;
      collect = 1'b1;
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            if (gaps) begin
               lfsr = step(lfsr);
               repeat (int'(lfsr[1:0])) begin @(posedge clk); #1; end
            end
            in_cyc[r][c] = cyc;
            push(img[r][c]);
         end
      repeat (4) @(posedge clk);
      #1;
      collect = 1'b0;
   endtask

   task automatic verify(input logic gaps, input int kind);
      string tag;
      check("R4 outputs per frame", got_n, NOUT);
      for (int i = 0; i < NOUT && i < got_n; i++) begin
         int r, c;
         r = 4 + i / (W - 4);
         c = 4 + i % (W - 4);
         if (gaps)          tag = "R7 value with gaps";
         else if (kind == 3) tag = "R2 impulse value";
         else if (r >= 5)   tag = "R3 value after bank wrap";
         else               tag = "R5 value";
         check(tag, int'(got_pix[i]), ref_px(r, c));
         if (kind == 0) check("R8 uniform 255", int'(got_pix[i]), 219);
         if (!gaps) check("R6 latency", got_cyc[i] - in_cyc[r][c], 2);
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; lfsr = 16'h1;
      do_reset();

      foreach (PLAN[i]) begin
         fill(int'(PLAN[i][11:8]), int'(PLAN[i][6:0]));
         do_reset();
         run_frame(PLAN[i][7]);
         verify(PLAN[i][7], int'(PLAN[i][11:8]));
      end

      // R1: partial rows before a reset must not leak into the next frame
      fill(4, 5);
      do_reset();
      got_n = 0;
      collect = 1'b1;
      for (int k = 0; k < 3 * W + 7; k++) push(8'hFF);
      collect = 1'b0;
      check("R1 no output before window fills", got_n, 0);
      do_reset();
      repeat (2) @(posedge clk);
      #1;
      check("R1 idle after reset", int'(out_valid), 0);
      run_frame(1'b0);
      verify(1'b0, 4);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule